// File: doc/BRIEF.md
# MDIO Management Frame Master

This block lets a host read and write 16-bit PHY registers over a two-wire management link made of a clock line and a bidirectional data line. The host places a PHY address, a register address, a read/write select and, for writes, 16 bits of data on the inputs and pulses `start`. The block then runs the whole transaction and reports completion with a one-cycle `done`. A read returns its result on `rd_data`.

The management clock `mdc` is made by dividing the system clock. The half-period is a parameter, counted in system clocks. The data line is driven through `mdio_o` and `mdio_oe`, so a pad cell can tristate it. The returning data arrives on `mdio_i` through a small synchronizer.

Every transaction has the same length of 96 management clock periods. It starts with a preamble of ones. A write then drives a full 32-bit command word. A read drives only the top 14 bits of its word, releases the line and samples 18 bits. Every transaction ends with a run of idle ones.

Top module: `mdio_frame_master`

## Requirements
- R1: Each transaction begins with PRE_LEN (default 32) management clock periods in which `mdio_oe` is 1 and `mdio_o` is 1.
- R2: The command word is 32 bits and is sent MSB first, one bit per `mdc` period. Its value is 0x60020000 for a read and 0x50020000 for a write, with the PHY address ORed in at bits 27:23 and the register address at bits 22:18. For a write, bits 15:0 carry `wr_data` and all 32 bits are driven with `mdio_oe` at 1.
- R3: For a read, only word bits 31:18 (14 bits) are driven. For the next 18 `mdc` periods `mdio_oe` is 0.
- R4: A read samples MDIO once in each of its 18 released periods, in the low half just before `mdc` rises, MSB first. `rd_data` then takes the last 16 samples and discards the first two. A write leaves `rd_data` unchanged.
- R5: While `mdc` is high, neither `mdio_o` nor `mdio_oe` changes. They change only together with, or after, a falling `mdc` edge.
- R6: Each high and each low half of `mdc` during a transaction lasts exactly HALF_DIV system clocks.
- R7: After the command (write) or the sampled bits (read), TAIL_LEN (default 32) periods follow with `mdio_oe` at 1 and `mdio_o` at 1.
- R8: `busy` goes high in the cycle after an accepted `start`. When the last idle period ends, `done` is high for exactly one cycle, and `busy` is already low in that cycle.
- R9: A `start` that arrives while `busy` is high is ignored. The transaction in progress is unchanged, and no second transaction follows it.
- R10: After reset, `mdc`, `mdio_oe`, `busy`, `done` and `rd_data` are 0 and `mdio_o` is 1.
- R11: While idle, `mdc` stays low, `mdio_oe` is 0 and `mdio_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Starts a transaction when idle |
| rd_sel | input | 1 | 1 = read, 0 = write |
| phy_addr | input | 5 | PHY address |
| reg_addr | input | 5 | Register address |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Result of the last read |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Data line drive value |
| mdio_oe | output | 1 | Data line drive enable |
| mdio_i | input | 1 | Data line input from the pad |

## Verification
The embedded properties check the following on every cycle of any run:
- the data line and its enable stay frozen while the clock is high;
- every clock half lasts exactly HALF_DIV cycles;
- `done` is a single pulse that coincides with `busy` being low;
- the last period before `done` drives an idle one;
- the latched read/write mode cannot change mid-transaction.

Only the bench's scenarios can show the rest:
- the actual frame content: the opcode, address placement and write data, bit by bit;
- the 14-versus-32 driven length;
- that 18 bits are sampled and only the last 16 are kept;
- that a write leaves the read result alone;
- that a mid-transaction `start` leaves no trace.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_PRE,
      PH_CMD,
      PH_RX,
      PH_TAIL
   } mdio_phase_e;

   localparam int FRAME_W   = 32;
   localparam int DATA_W    = 16;
   localparam int ADDR_W    = 5;
   localparam int RD_DRIVE  = 14;
   localparam int RD_SAMPLE = 18;
   localparam int PHY_LSB   = 23;
   localparam int REG_LSB   = 18;

   localparam logic [FRAME_W-1:0] OPW_RD = 32'h6002_0000;
   localparam logic [FRAME_W-1:0] OPW_WR = 32'h5002_0000;

   function automatic logic [FRAME_W-1:0] build_frame(
      input logic              rd,
      input logic [ADDR_W-1:0] pa,
      input logic [ADDR_W-1:0] ra,
      input logic [DATA_W-1:0] wd
   );
      logic [FRAME_W-1:0] w;
      w = rd ? OPW_RD : OPW_WR;
      w = w | (FRAME_W'(pa) << PHY_LSB);
      w = w | (FRAME_W'(ra) << REG_LSB);
      if (!rd)
         w = w | FRAME_W'(wd);
      return w;
   endfunction

endpackage

// File: rtl/mdio_half_timer.sv
module mdio_half_timer #(
   parameter int HALF_DIV = 20
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic tick
);
   localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

   generate
      if (HALF_DIV < 2) begin : g_bad_div
         $error("mdio_half_timer: HALF_DIV must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign tick = run && (cnt == CW'(HALF_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || tick)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

endmodule

// File: rtl/mdio_seq.sv
module mdio_seq
   import mdio_pkg::*;
#(
   parameter int PRE_LEN  = 32,
   parameter int TAIL_LEN = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        rd_sel,
   input  logic        tick,
   output mdio_phase_e phase,
   output logic        busy,
   output logic        mdc,
   output logic        load,
   output logic        shift_en,
   output logic        sample_en,
   output logic        capture_en,
   output logic        done
);
   localparam int MAXB_A = (PRE_LEN > TAIL_LEN) ? PRE_LEN : TAIL_LEN;
   localparam int MAXB   = (MAXB_A > FRAME_W) ? MAXB_A : FRAME_W;
   localparam int CNT_W  = $clog2(MAXB + 1);

   generate
      if (PRE_LEN < 1 || TAIL_LEN < 1) begin : g_bad_len
         $error("mdio_seq: PRE_LEN and TAIL_LEN must be positive");
      end
   endgenerate

   logic [CNT_W-1:0] bcnt;
   logic [CNT_W-1:0] last_bit;
   logic             hi;
   logic             is_rd;
   mdio_phase_e      next_phase;

   always_comb begin
      case (phase)
         PH_PRE:  last_bit = CNT_W'(PRE_LEN - 1);
         PH_CMD:  last_bit = is_rd ? CNT_W'(RD_DRIVE - 1) : CNT_W'(FRAME_W - 1);
         PH_RX:   last_bit = CNT_W'(RD_SAMPLE - 1);
         PH_TAIL: last_bit = CNT_W'(TAIL_LEN - 1);
         default: last_bit = '0;
      endcase
   end

   always_comb begin
      case (phase)
         PH_PRE:  next_phase = PH_CMD;
         PH_CMD:  next_phase = is_rd ? PH_RX : PH_TAIL;
         PH_RX:   next_phase = PH_TAIL;
         default: next_phase = PH_IDLE;
      endcase
   end

   assign busy       = (phase != PH_IDLE);
   assign mdc        = hi;
   assign load       = (phase == PH_IDLE) && start;
   assign shift_en   = tick && hi && (phase == PH_CMD);
   assign sample_en  = tick && !hi && (phase == PH_RX);
   assign capture_en = tick && hi && (phase == PH_RX) && (bcnt == last_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase <= PH_IDLE;
         bcnt  <= '0;
         hi    <= 1'b0;
         is_rd <= 1'b0;
         done  <= 1'b0;
      end else begin
         done <= 1'b0;
         if (phase == PH_IDLE) begin
            if (start) begin
               phase <= PH_PRE;
               bcnt  <= '0;
               hi    <= 1'b0;
               is_rd <= rd_sel;
            end
         end else if (tick) begin
            if (!hi) begin
               hi <= 1'b1;
            end else begin
               hi <= 1'b0;
               if (bcnt == last_bit) begin
                  bcnt  <= '0;
                  phase <= next_phase;
                  if (phase == PH_TAIL)
                     done <= 1'b1;
               end else begin
                  bcnt <= bcnt + 1'b1;
               end
            end
         end
      end
   end

   // R8: completion is a single pulse seen while already idle
   p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_busy_after_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> busy);
   // R9: a start during a transaction cannot change its mode
   p_mode_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(is_rd));

endmodule

// File: rtl/mdio_shift_path.sv
module mdio_shift_path
   import mdio_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] load_word,
   input  logic               shift_en,
   input  logic               sample_en,
   input  logic               capture_en,
   input  logic               mdio_in,
   output logic               tx_msb,
   output logic [DATA_W-1:0]  rd_data
);
   generate
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("mdio_shift_path: SYNC_STAGES must be 0 to 3");
      end
   endgenerate

   logic mdio_s;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign mdio_s = mdio_in;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sync_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               sync_q <= '1;
            else if (SYNC_STAGES == 1)
               sync_q <= mdio_in;
            else
               sync_q <= {sync_q[SYNC_STAGES-2:0], mdio_in};
         end
         assign mdio_s = sync_q[SYNC_STAGES-1];
      end
   endgenerate

   logic [FRAME_W-1:0] tx_sh;
   logic [DATA_W-1:0]  rx_sh;

   assign tx_msb = tx_sh[FRAME_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tx_sh <= '1;
      else if (load)
         tx_sh <= load_word;
      else if (shift_en)
         tx_sh <= {tx_sh[FRAME_W-2:0], 1'b1};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rx_sh <= '0;
      else if (sample_en)
         rx_sh <= {rx_sh[DATA_W-2:0], mdio_s};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_data <= '0;
      else if (capture_en)
         rd_data <= rx_sh;
   end

endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
   import mdio_pkg::*;
#(
   parameter int HALF_DIV    = 20,
   parameter int PRE_LEN     = 32,
   parameter int TAIL_LEN    = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   input  logic        rd_sel,
   input  logic [4:0]  phy_addr,
   input  logic [4:0]  reg_addr,
   input  logic [15:0] wr_data,
   output logic [15:0] rd_data,
   output logic        busy,
   output logic        done,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   mdio_phase_e phase;
   logic        tick;
   logic        load;
   logic        shift_en;
   logic        sample_en;
   logic        capture_en;
   logic        tx_msb;

   mdio_half_timer #(.HALF_DIV(HALF_DIV)) u_timer (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .tick (tick)
   );

   mdio_seq #(.PRE_LEN(PRE_LEN), .TAIL_LEN(TAIL_LEN)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .rd_sel    (rd_sel),
      .tick      (tick),
      .phase     (phase),
      .busy      (busy),
      .mdc       (mdc),
      .load      (load),
      .shift_en  (shift_en),
      .sample_en (sample_en),
      .capture_en(capture_en),
      .done      (done)
   );

   mdio_shift_path #(.SYNC_STAGES(SYNC_STAGES)) u_path (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_word (build_frame(rd_sel, phy_addr, reg_addr, wr_data)),
      .shift_en  (shift_en),
      .sample_en (sample_en),
      .capture_en(capture_en),
      .mdio_in   (mdio_i),
      .tx_msb    (tx_msb),
      .rd_data   (rd_data)
   );

   assign mdio_o  = (phase == PH_CMD) ? tx_msb : 1'b1;
   assign mdio_oe = (phase == PH_PRE) || (phase == PH_CMD) || (phase == PH_TAIL);

   // checker state: clock level one cycle back and length of the current half
   logic        mdc_q;
   logic [15:0] gap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mdc_q <= 1'b0;
         gap   <= '0;
      end else begin
         mdc_q <= mdc;
         if (mdc != mdc_q)
            gap <= 16'd1;
         else if (busy)
            gap <= gap + 16'd1;
         else
            gap <= '0;
      end
   end

   // R5: data line and enable frozen while the clock is high
   p_stable_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
      mdc |-> ($stable(mdio_o) && $stable(mdio_oe)));
   // R6: each clock half is HALF_DIV system clocks
   p_half_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc != mdc_q) |-> (gap == 16'(HALF_DIV)));
   // R7: the period just before completion drives an idle one
   p_tail_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ($past(mdio_oe) && $past(mdio_o)));
   // R11: no clock and no drive while idle
   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> (!mdc && !mdio_oe));

endmodule

// File: tb/mdio_frame_master_bench.sv
`timescale 1ns/1ps
module mdio_frame_master_bench;
   localparam int H = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        rd_sel = 1'b0;
   logic [4:0]  phy_addr = '0;
   logic [4:0]  reg_addr = '0;
   logic [15:0] wr_data = '0;
   logic [15:0] rd_data;
   logic        busy, done, mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;

   always #2.5 clk = ~clk;

   mdio_frame_master #(.HALF_DIV(H)) u_mdio_frame_master (
      .clk(clk), .rst_n(rst_n), .start(start), .rd_sel(rd_sel),
      .phy_addr(phy_addr), .reg_addr(reg_addr), .wr_data(wr_data),
      .rd_data(rd_data), .busy(busy), .done(done), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   typedef struct packed {
      logic        rd;
      logic [31:0] word;
      logic [17:0] resp;
      logic [15:0] exp_rd;
   } item_t;

   item_t       sbq[$];
   int          checks = 0;
   int          errors = 0;
   logic [15:0] model_rd = '0;
   bit          finished = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor state
   int   nrise = 0;
   bit   rec_o  [0:127];
   bit   rec_oe [0:127];
   logic prev_mdc = 1'b0, prev_o = 1'b1, prev_oe = 1'b0;
   int   run_len = 0;
   int   stab_err = 0;
   int   per_err = 0;

   always @(negedge clk) begin
      if (rst_n) begin
         if (mdc && prev_mdc && (mdio_o !== prev_o || mdio_oe !== prev_oe))
            stab_err++;
         if (mdc !== prev_mdc) begin
            if (prev_mdc && run_len != H) per_err++;
            if (!prev_mdc && nrise > 0 && run_len != H) per_err++;
            run_len = 1;
         end else begin
            run_len++;
         end
         if (mdc && !prev_mdc) begin
            if (nrise < 128) begin
               rec_o[nrise]  = mdio_o;
               rec_oe[nrise] = mdio_oe;
            end
            nrise++;
         end
         // PHY model: present the response bit for the coming period
         if (sbq.size() > 0 && sbq[0].rd && nrise >= 46 && nrise < 64)
            mdio_i = sbq[0].resp[17 - (nrise - 46)];
         else
            mdio_i = 1'b1;
         if (done) begin
            logic [31:0] a_pre_o, a_pre_oe, a_cmd, a_cmd_oe, a_tl_o, a_tl_oe;
            logic [17:0] a_rx_oe;
            item_t e;
            for (int k = 0; k < 32; k++) begin
               a_pre_o[31-k]  = rec_o[k];
               a_pre_oe[31-k] = rec_oe[k];
               a_cmd[31-k]    = rec_o[32+k];
               a_cmd_oe[31-k] = rec_oe[32+k];
               a_tl_o[31-k]   = rec_o[64+k];
               a_tl_oe[31-k]  = rec_oe[64+k];
            end
            for (int k = 0; k < 18; k++) a_rx_oe[17-k] = rec_oe[46+k];
            if (sbq.size() == 0) begin
               chk(0, "R8 unexpected done", 32'd1, 32'd0);
            end else begin
               e = sbq.pop_front();
               chk(nrise == 96, "R2 period count", 32'(nrise), 32'd96);
               chk(a_pre_o == '1 && a_pre_oe == '1, "R1 preamble", a_pre_o & a_pre_oe, 32'hFFFF_FFFF);
               if (e.rd) begin
                  chk(a_cmd[31:18] == e.word[31:18] && a_cmd_oe[31:18] == '1,
                      "R3 driven read bits", {18'd0, a_cmd[31:18]}, {18'd0, e.word[31:18]});
                  chk(a_rx_oe == '0, "R3 released bits", {14'd0, a_rx_oe}, 32'd0);
                  chk(rd_data == e.exp_rd, "R4 read data", {16'd0, rd_data}, {16'd0, e.exp_rd});
               end else begin
                  chk(a_cmd == e.word && a_cmd_oe == '1, "R2 write word", a_cmd, e.word);
                  chk(rd_data == e.exp_rd, "R4 write keeps read data", {16'd0, rd_data}, {16'd0, e.exp_rd});
               end
               chk(a_tl_o == '1 && a_tl_oe == '1, "R7 trailing idle", a_tl_o & a_tl_oe, 32'hFFFF_FFFF);
               chk(stab_err == 0, "R5 change while clock high", 32'(stab_err), 32'd0);
               chk(per_err == 0, "R6 half period", 32'(per_err), 32'd0);
            end
            nrise = 0; stab_err = 0; per_err = 0;
         end
      end
      prev_mdc = mdc; prev_o = mdio_o; prev_oe = mdio_oe;
   end

   // driver: push the expectation, launch, wait for completion
   task automatic do_op(input bit rd, input logic [4:0] pa, input logic [4:0] ra,
                        input logic [15:0] wd, input logic [17:0] resp, input bit poke);
      item_t e;
      e.rd   = rd;
      e.word = (rd ? 32'h6002_0000 : 32'h5002_0000) | (32'(pa) << 23) | (32'(ra) << 18)
               | (rd ? 32'd0 : 32'(wd));
      e.resp = resp;
      if (rd) model_rd = resp[15:0];
      e.exp_rd = model_rd;
      sbq.push_back(e);
      @(negedge clk);
      rd_sel = rd; phy_addr = pa; reg_addr = ra; wr_data = wd; start = 1'b1;
      @(negedge clk);
      chk(busy === 1'b1, "R8 busy after start", {31'd0, busy}, 32'd1);
      start = 1'b0;
      if (poke) begin
         repeat (200) @(negedge clk);
         rd_sel = ~rd; phy_addr = 5'd3; reg_addr = 5'd4; wr_data = 16'h1234; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (!done) @(negedge clk);
      chk(busy === 1'b0, "R8 busy low with done", {31'd0, busy}, 32'd0);
      @(negedge clk);
      chk(done === 1'b0, "R8 done one cycle", {31'd0, done}, 32'd0);
      repeat (30) @(negedge clk);
      chk(!busy && !mdc && !mdio_oe && mdio_o, "R11 idle lines",
          {28'd0, busy, mdc, mdio_oe, mdio_o}, 32'd1);
      if (poke)
         chk(!busy && nrise == 0, "R9 ignored start left no transaction",
             {31'd0, busy}, 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(mdc === 1'b0 && mdio_oe === 1'b0 && mdio_o === 1'b1, "R10 line reset",
          {29'd0, mdc, mdio_oe, mdio_o}, 32'd1);
      chk(busy === 1'b0 && done === 1'b0, "R10 status reset", {30'd0, busy, done}, 32'd0);
      chk(rd_data === 16'd0, "R10 read data reset", {16'd0, rd_data}, 32'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      chk(!busy && !mdc && !mdio_oe, "R11 idle after reset", {29'd0, busy, mdc, mdio_oe}, 32'd0);
      do_op(1'b0, 5'h01, 5'h00, 16'hA5C3, 18'd0, 1'b0);
      do_op(1'b1, 5'h1F, 5'h1F, 16'h0000, {2'b11, 16'h8001}, 1'b0);
      do_op(1'b1, 5'h00, 5'h05, 16'hFFFF, {2'b00, 16'h7FFE}, 1'b0);
      do_op(1'b0, 5'h15, 5'h0A, 16'hFFFF, 18'd0, 1'b1);
      do_op(1'b1, 5'h0A, 5'h15, 16'h0000, {2'b10, 16'h5AA5}, 1'b1);
      do_op(1'b0, 5'h00, 5'h00, 16'h0000, 18'd0, 1'b0);
      chk(sbq.size() == 0, "R8 all transactions completed", 32'(sbq.size()), 32'd0);
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL R8 watchdog expired actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule